// File: doc/BRIEF.md
# Set-Associative Data Cache with Snoop Invalidation

This block sits between a processor's data port and a word-wide main-memory port. It holds recently used memory lines in a K-way set-associative array. Each line carries a tag, a row of data words, a line valid bit, a dirty bit and one valid bit per word. A read that finds its word present is answered in the same cycle. A read that does not find it fetches the line one word per memory beat. A mode input chooses, at run time, whether processor writes also go to memory at once or stay in the cache until the line is evicted.

A separate observation port reports writes that other bus masters make to memory. Any cached line those writes touch is dropped, so a later processor read goes back to memory. A processor write to a line that is not present claims a way without a line fetch. Only the written word is marked present in that line. Replacement inside a set follows least-recently-used order.

The processor holds `cpu_req` and its address, write flag and data steady until `cpu_ready`. `cpu_ready` is high for exactly one clock edge. The memory side holds `mem_req` and its fields steady until one `mem_ack` cycle completes the beat. The mode input is changed only while no request is outstanding.

Top module: `assoc_snoop_cache`

## Requirements
- R1: After reset no line is present. `cpu_ready` and `mem_req` are low in reset, and the first read of any address causes memory reads.
- R2: A read whose line is present and whose word is marked present raises `cpu_ready` in the same cycle it is presented, with the stored word and no memory request.
- R3: A read miss fetches all WORDS words of the line. It starts at the word after the requested offset and wraps around, so the requested word is the last beat. `cpu_ready` rises in the cycle of that last `mem_ack`, and `cpu_rdata` equals `mem_rdata` in that cycle. The other words of the line then hit.
- R4: With `wb_mode` low, a processor write updates the cache and issues one memory write of the same address and data. `cpu_ready` rises with that write's `mem_ack`.
- R5: With `wb_mode` high, a processor write touches only the cache and raises `cpu_ready` with no memory request. When a dirty line is replaced, its present words are written to memory in ascending offset order before the new line is fetched.
- R6: A write that misses claims a way without any memory read and marks only the written word present. A later read of that word hits. A read of another word in that line fetches the line but keeps the written word.
- R7: A miss fills the lowest-numbered way that holds no line. When every way of the set holds a line, the least recently used way is replaced. Both hits and fills count as use.
- R8: When `snp_valid` is high and `snp_addr` falls in a present line, that line is dropped, even if it is dirty. The next read of that line misses and returns memory's current data. In a cycle with `snp_valid` high, the cache starts no processor access.
- R9: If an observed write hits the line being fetched, the fetch still runs to its last beat. The line is then dropped, `cpu_ready` stays low, and the read is fetched again from memory.
- R10: Word address bits [1:0] select the word, bits [5:2] select one of 16 sets, and bits [11:6] form the tag. Lines with different set bits never displace each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_mode | input | 1 | 1: write-back, 0: write-through |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | 12 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ready | output | 1 | Access completes on this edge |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1: memory write beat, 0: read beat |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Beat accepted or read data present |
| mem_rdata | input | 32 | Memory read data |
| snp_valid | input | 1 | Another master writes memory this cycle |
| snp_addr | input | 12 | Word address of that write |

## Verification
The bound checker watches handshake rules on every cycle:
- a ready never occurs without a request;
- a memory beat holds until it is acknowledged;
- fetches stay on the requesting line;
- the forwarded word equals the last fetched beat;
- a write-through completion coincides with a matching memory write;
- a write-back completion occurs with the memory port idle.

Several behaviours need stored history and only the bench scenarios can show them. These are LRU victim choice, dirty-line eviction order and content, dropping of lines after an observed write, and the refetch after an observed write hits a line mid-fill. The bench sweeps every set and word and compares results against a memory model it keeps itself.

// File: rtl/cachesnp_pkg.sv
// Shared types for the snooping set-associative cache.
package cachesnp_pkg;
    // Controller phases: lookup, write-through beat, dirty writeback, line fetch.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_EVICT = 2'd2,
        ST_FILL  = 2'd3
    } cstate_e;
endpackage

// File: rtl/cache_way_match.sv
// Compares one query tag against the tags of all ways of one set at once.
// Assumes at most one valid way holds a given tag; returns the index of it.
module cache_way_match #(
    parameter int WAYS = 4,
    parameter int TW   = 6,
    localparam int WI  = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][TW-1:0] set_tags,
    input  logic [WAYS-1:0]         set_vld,
    input  logic [TW-1:0]           q_tag,
    output logic                    hit,
    output logic [WI-1:0]           hit_way
);
    logic [WAYS-1:0] hv;

    // One comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hv[w] = set_vld[w] && (set_tags[w] == q_tag);
    end

    // Reduce the match vector to a flag and an index.
    always_comb begin
        hit     = |hv;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hv[w]) hit_way = WI'(w);
        end
    end
endmodule

// File: rtl/cache_lru.sv
// Per-set recency ranks (0 = newest, WAYS-1 = oldest) and victim choice.
// Assumes ranks in a set always form a permutation; reset sets rank = way.
module cache_lru #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WI  = $clog2(WAYS),
    localparam int IB  = $clog2(SETS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch,
    input  logic [IB-1:0]   touch_set,
    input  logic [WI-1:0]   touch_way,
    input  logic [IB-1:0]   q_set,
    input  logic [WAYS-1:0] q_vld,
    output logic [WI-1:0]   victim
);
    logic [WI-1:0] age_q [SETS][WAYS];

    // Promote the touched way to newest and age the ones that were newer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WI'(w);
        end else if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WI'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + WI'(1);
            end
        end
    end

    // Lowest empty way first, otherwise the oldest way.
    always_comb begin
        logic found;
        victim = '0;
        found  = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !q_vld[w]) begin
                victim = WI'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[q_set][w] == WI'(WAYS-1)) victim = WI'(w);
            end
        end
    end
endmodule

// File: rtl/assoc_snoop_cache.sv
// K-way set-associative data cache with run-time write-through/write-back
// choice, per-word valid bits and invalidation from an observed-write port.
// Assumes: CPU holds request fields until cpu_ready; memory holds a beat
// until mem_ack; wb_mode changes only between requests; WAYS, SETS, WORDS
// are powers of two, each at least 2.
module assoc_snoop_cache
    import cachesnp_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 16,
    parameter int WORDS = 4,
    parameter int DW    = 32,
    parameter int AW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_mode,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          snp_valid,
    input  logic [AW-1:0] snp_addr
);
    localparam int OB = $clog2(WORDS);
    localparam int IB = $clog2(SETS);
    localparam int TW = AW - OB - IB;
    localparam int WI = $clog2(WAYS);

    // Line storage.
    logic [TW-1:0]    tag_q   [SETS][WAYS];
    logic [WAYS-1:0]  vld_q   [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WORDS-1:0] wvld_q  [SETS][WAYS];
    logic [DW-1:0]    data_q  [SETS][WAYS][WORDS];

    // Controller state.
    cstate_e       state_q;
    logic [OB-1:0] cnt_q;
    logic [WI-1:0] way_q;
    logic          snp_flag_q;

    // Address fields.
    logic [OB-1:0] c_off;
    logic [IB-1:0] c_idx, s_idx;
    logic [TW-1:0] c_tag, s_tag;
    assign c_off = cpu_addr[OB-1:0];
    assign c_idx = cpu_addr[OB +: IB];
    assign c_tag = cpu_addr[AW-1 -: TW];
    assign s_idx = snp_addr[OB +: IB];
    assign s_tag = snp_addr[AW-1 -: TW];

    logic [WAYS-1:0][TW-1:0] c_tags, s_tags;

    // Gather the tags of the CPU set and of the observed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            c_tags[w] = tag_q[c_idx][w];
            s_tags[w] = tag_q[s_idx][w];
        end
    end

    logic          c_hit, s_hit;
    logic [WI-1:0] c_way, s_way, vic;

    cache_way_match #(.WAYS(WAYS), .TW(TW)) u_cmatch (
        .set_tags(c_tags), .set_vld(vld_q[c_idx]), .q_tag(c_tag),
        .hit(c_hit), .hit_way(c_way)
    );

    cache_way_match #(.WAYS(WAYS), .TW(TW)) u_smatch (
        .set_tags(s_tags), .set_vld(vld_q[s_idx]), .q_tag(s_tag),
        .hit(s_hit), .hit_way(s_way)
    );

    logic          touch;
    logic [WI-1:0] touch_way;

    cache_lru #(.WAYS(WAYS), .SETS(SETS)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_set(c_idx),
        .touch_way(touch_way), .q_set(c_idx), .q_vld(vld_q[c_idx]),
        .victim(vic)
    );

    // Derived control terms.
    logic             go, word_ok, vic_dirty, last_beat, line_snooped;
    logic             ev_word_ok, adv_evict;
    logic [OB-1:0]    fill_off;
    logic [WORDS-1:0] c_onehot;
    assign go           = (state_q == ST_IDLE) && cpu_req && !snp_valid;
    assign word_ok      = wvld_q[c_idx][c_way][c_off];
    assign vic_dirty    = vld_q[c_idx][vic] && dirty_q[c_idx][vic];
    assign last_beat    = (cnt_q == OB'(WORDS-1));
    assign fill_off     = c_off + cnt_q + OB'(1);
    assign line_snooped = snp_valid && (snp_addr[AW-1:OB] == cpu_addr[AW-1:OB]);
    assign ev_word_ok   = wvld_q[c_idx][way_q][cnt_q];
    assign adv_evict    = mem_ack || !ev_word_ok;
    assign c_onehot     = WORDS'(1) << c_off;

    // Port outputs and recency updates per phase.
    always_comb begin
        cpu_ready = 1'b0;
        cpu_rdata = data_q[c_idx][c_way][c_off];
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cpu_addr;
        mem_wdata = cpu_wdata;
        touch     = 1'b0;
        touch_way = c_way;
        case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (c_hit) begin
                        touch = 1'b1;
                        if ((!cpu_we && word_ok) || (cpu_we && wb_mode))
                            cpu_ready = 1'b1;
                    end else if (!vic_dirty) begin
                        touch     = 1'b1;
                        touch_way = vic;
                        if (cpu_we && wb_mode) cpu_ready = 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                cpu_ready = mem_ack;
            end
            ST_EVICT: begin
                mem_req   = ev_word_ok;
                mem_we    = 1'b1;
                mem_addr  = {tag_q[c_idx][way_q], c_idx, cnt_q};
                mem_wdata = data_q[c_idx][way_q][cnt_q];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {c_tag, c_idx, fill_off};
                if (mem_ack && last_beat && !snp_flag_q && !line_snooped) begin
                    cpu_ready = 1'b1;
                    cpu_rdata = mem_rdata;
                end
            end
            default: ;
        endcase
    end

    // Phase sequencing and beat counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            way_q      <= '0;
            snp_flag_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q      <= '0;
                    snp_flag_q <= 1'b0;
                    if (go) begin
                        if (c_hit) begin
                            way_q <= c_way;
                            if (!cpu_we && !word_ok) state_q <= ST_FILL;
                            else if (cpu_we && !wb_mode) state_q <= ST_WRITE;
                        end else begin
                            way_q <= vic;
                            if (vic_dirty) state_q <= ST_EVICT;
                            else if (!cpu_we) state_q <= ST_FILL;
                            else if (!wb_mode) state_q <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: if (mem_ack) state_q <= ST_IDLE;
                ST_EVICT: begin
                    if (adv_evict) begin
                        cnt_q <= cnt_q + OB'(1);
                        if (last_beat) state_q <= ST_IDLE;
                    end
                end
                ST_FILL: begin
                    if (line_snooped) snp_flag_q <= 1'b1;
                    if (mem_ack) begin
                        cnt_q <= cnt_q + OB'(1);
                        if (last_beat) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Line valid and dirty bits: reset, snoop drop, allocate, evict, fill end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s]   <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            if (snp_valid && s_hit) vld_q[s_idx][s_way] <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (go && c_hit && cpu_we && wb_mode)
                        dirty_q[c_idx][c_way] <= 1'b1;
                    else if (go && !c_hit && !vic_dirty) begin
                        vld_q[c_idx][vic]   <= 1'b1;
                        dirty_q[c_idx][vic] <= cpu_we && wb_mode;
                    end
                end
                ST_EVICT: begin
                    if (adv_evict && last_beat) begin
                        vld_q[c_idx][way_q]   <= 1'b0;
                        dirty_q[c_idx][way_q] <= 1'b0;
                    end
                end
                ST_FILL: begin
                    if (mem_ack && last_beat)
                        vld_q[c_idx][way_q] <= !(snp_flag_q || line_snooped);
                end
                default: ;
            endcase
        end
    end

    // Tags, word-valid bits and data words (no reset: gated by line valid).
    always_ff @(posedge clk) begin
        if (go && c_hit && cpu_we) begin
            data_q[c_idx][c_way][c_off] <= cpu_wdata;
            wvld_q[c_idx][c_way][c_off] <= 1'b1;
        end else if (go && !c_hit && !vic_dirty) begin
            tag_q[c_idx][vic]  <= c_tag;
            wvld_q[c_idx][vic] <= cpu_we ? c_onehot : '0;
            if (cpu_we) data_q[c_idx][vic][c_off] <= cpu_wdata;
        end
        if (state_q == ST_FILL && mem_ack && !wvld_q[c_idx][way_q][fill_off]) begin
            data_q[c_idx][way_q][fill_off] <= mem_rdata;
            wvld_q[c_idx][way_q][fill_off] <= 1'b1;
        end
    end
endmodule

// File: rtl/assoc_snoop_cache_chk.sv
// Port-level protocol checks for assoc_snoop_cache, bound to every instance.
module assoc_snoop_cache_chk #(
    parameter int AW = 12,
    parameter int DW = 32,
    parameter int OB = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wb_mode,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic [AW-1:0] cpu_addr,
    input logic [DW-1:0] cpu_wdata,
    input logic          cpu_ready,
    input logic [DW-1:0] cpu_rdata,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic [DW-1:0] mem_rdata
);
    // R2: completion only answers a pending request.
    p_ready_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R3: fetch beats stay within the requesting line.
    p_fill_same_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (cpu_req && mem_addr[AW-1:OB] == cpu_addr[AW-1:OB]));

    // R3: a read finishing on a memory beat forwards that beat's word.
    p_fill_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && !cpu_we && mem_ack) |->
        (!mem_we && mem_addr == cpu_addr && cpu_rdata == mem_rdata));

    // R3: an unacknowledged beat keeps its request, address and direction.
    p_beat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: a write-through completion is the matching memory write beat.
    p_wt_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && !wb_mode) |->
        (mem_req && mem_ack && mem_we && mem_addr == cpu_addr && mem_wdata == cpu_wdata));

    // R5: a write-back completion leaves the memory port idle.
    p_wb_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && wb_mode) |-> !mem_req);
endmodule

bind assoc_snoop_cache assoc_snoop_cache_chk #(
    .AW(AW), .DW(DW), .OB($clog2(WORDS))
) u_chk (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
);

// File: tb/sim_assoc_snoop_cache.sv
`timescale 1ns/1ps
// Self-checking bench: memory model, CPU driver, observed-write injector.
module sim_assoc_snoop_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wb_mode = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [11:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [11:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        snp_valid = 1'b0;
    logic [11:0] snp_addr = '0;

    int tests = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
    logic [31:0] model [4096];
    logic [11:0] rd_log [16];

    always #10 clk = ~clk;

    assoc_snoop_cache u0 (
        .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .snp_valid(snp_valid),
        .snp_addr(snp_addr)
    );

    function automatic logic [11:0] ad(int t, int s, int w);
        return 12'(t * 64 + s * 4 + w);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one wait cycle on alternate beats, ack for one cycle.
    initial begin
        int dly = 0;
        for (int i = 0; i < 4096; i++) model[i] = 32'h1000_0000 + i * 32'h0001_0003;
        forever begin
            @(negedge clk); #1;
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && rst_n) begin
                if (dly == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) begin
                        model[mem_addr] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata = model[mem_addr];
                        rd_log[rd_cnt % 16] = mem_addr;
                        rd_cnt++;
                    end
                    dly = (rd_cnt + wr_cnt) % 2;
                end else dly--;
            end
        end
    end

    // One CPU access; reports data, memory beats used and cycles waited.
    task automatic acc(input bit we, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] q, output int dr, output int dw, output int waitc);
        int r0 = rd_cnt, w0 = wr_cnt;
        waitc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #5;
        while (!cpu_ready && waitc < 500) begin
            waitc++;
            @(negedge clk); #5;
        end
        if (waitc >= 500) chk(0, "access timeout", 32'(a), 32'(a));
        q = cpu_rdata;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        dr = rd_cnt - r0;
        dw = wr_cnt - w0;
    endtask

    // Another master writes memory: update the model and pulse the snoop port.
    task automatic ext_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        model[a] = d;
        snp_valid = 1'b1; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] q, old;
        int dr, dw, wc;
        repeat (4) @(negedge clk);
        #5;
        // R1: reset state at the ports.
        chk(!cpu_ready && !mem_req, "R1 reset outputs", {30'd0, cpu_ready, mem_req}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R3: wrap order, requested word last, forwarded value.
        acc(0, ad(0, 0, 1), 0, q, dr, dw, wc);
        chk(q == model[ad(0, 0, 1)], "R3 miss data", q, model[ad(0, 0, 1)]);
        chk(dr == 4, "R1 first read fetches", 32'(dr), 32'd4);
        chk(rd_log[0] == ad(0, 0, 2) && rd_log[1] == ad(0, 0, 3) &&
            rd_log[2] == ad(0, 0, 0) && rd_log[3] == ad(0, 0, 1),
            "R3 beat order", {rd_log[0][3:0], rd_log[1][3:0], rd_log[2][3:0], rd_log[3][3:0], 16'd0},
            32'h2301_0000);

        // R10/R1: every other set misses once, independently.
        for (int s = 1; s < 16; s++) begin
            acc(0, ad(0, s, s % 4), 0, q, dr, dw, wc);
            chk(q == model[ad(0, s, s % 4)] && dr == 4, "R10 set fill", q, model[ad(0, s, s % 4)]);
        end

        // R2: full sweep of every word of every set hits at once.
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < 4; w++) begin
                acc(0, ad(0, s, w), 0, q, dr, dw, wc);
                chk(q == model[ad(0, s, w)] && dr == 0 && wc == 0, "R2 hit sweep",
                    q, model[ad(0, s, w)]);
            end
        end

        // R7: LRU in set 5.
        for (int t = 1; t < 4; t++) begin
            acc(0, ad(t, 5, 0), 0, q, dr, dw, wc);
            chk(dr == 4, "R7 fill empty way", 32'(dr), 32'd4);
        end
        acc(0, ad(0, 5, 3), 0, q, dr, dw, wc);
        chk(dr == 0, "R7 touch oldest", 32'(dr), 32'd0);
        acc(0, ad(4, 5, 0), 0, q, dr, dw, wc);
        chk(dr == 4 && q == model[ad(4, 5, 0)], "R7 replace", q, model[ad(4, 5, 0)]);
        acc(0, ad(0, 5, 0), 0, q, dr, dw, wc);
        chk(dr == 0, "R7 recent kept", 32'(dr), 32'd0);
        acc(0, ad(2, 5, 0), 0, q, dr, dw, wc);
        chk(dr == 0, "R7 way kept", 32'(dr), 32'd0);
        acc(0, ad(3, 5, 0), 0, q, dr, dw, wc);
        chk(dr == 0, "R7 way kept", 32'(dr), 32'd0);
        acc(0, ad(1, 5, 0), 0, q, dr, dw, wc);
        chk(dr == 4, "R7 victim gone", 32'(dr), 32'd4);

        // R4: write-through.
        wb_mode = 1'b0;
        acc(1, ad(0, 6, 2), 32'hDEAD_0006, q, dr, dw, wc);
        chk(dw == 1 && dr == 0, "R4 one memory write", 32'(dw), 32'd1);
        chk(model[ad(0, 6, 2)] == 32'hDEAD_0006, "R4 memory data", model[ad(0, 6, 2)], 32'hDEAD_0006);
        acc(0, ad(0, 6, 2), 0, q, dr, dw, wc);
        chk(q == 32'hDEAD_0006 && dr == 0, "R4 cache data", q, 32'hDEAD_0006);

        // R5: write-back, then eviction of the dirty line.
        wb_mode = 1'b1;
        old = model[ad(0, 7, 1)];
        acc(1, ad(0, 7, 1), 32'hBEEF_0007, q, dr, dw, wc);
        chk(dw == 0 && dr == 0 && wc == 0, "R5 no memory access", 32'(dw), 32'd0);
        chk(model[ad(0, 7, 1)] == old, "R5 memory untouched", model[ad(0, 7, 1)], old);
        acc(0, ad(0, 7, 1), 0, q, dr, dw, wc);
        chk(q == 32'hBEEF_0007 && dr == 0, "R5 cache data", q, 32'hBEEF_0007);
        for (int t = 1; t < 4; t++) acc(0, ad(t, 7, 0), 0, q, dr, dw, wc);
        acc(0, ad(4, 7, 0), 0, q, dr, dw, wc);
        chk(dw == 4 && dr == 4, "R5 writeback then fetch", 32'(dw), 32'd4);
        chk(model[ad(0, 7, 1)] == 32'hBEEF_0007, "R5 written back", model[ad(0, 7, 1)], 32'hBEEF_0007);
        chk(q == model[ad(4, 7, 0)], "R5 new line data", q, model[ad(4, 7, 0)]);

        // R6: write allocate with per-word valid.
        old = model[ad(8, 9, 2)];
        acc(1, ad(8, 9, 2), 32'hCAFE_0009, q, dr, dw, wc);
        chk(dr == 0 && dw == 0, "R6 no fetch on write miss", 32'(dr), 32'd0);
        acc(0, ad(8, 9, 2), 0, q, dr, dw, wc);
        chk(q == 32'hCAFE_0009 && dr == 0, "R6 written word hits", q, 32'hCAFE_0009);
        acc(0, ad(8, 9, 0), 0, q, dr, dw, wc);
        chk(q == model[ad(8, 9, 0)] && dr == 4, "R6 other word fetched", q, model[ad(8, 9, 0)]);
        acc(0, ad(8, 9, 2), 0, q, dr, dw, wc);
        chk(q == 32'hCAFE_0009 && dr == 0, "R6 written word kept", q, 32'hCAFE_0009);

        // R8: observed writes drop lines.
        ext_write(ad(0, 3, 1), 32'h5A5A_0003);
        acc(0, ad(0, 3, 1), 0, q, dr, dw, wc);
        chk(q == 32'h5A5A_0003 && dr == 4, "R8 refetch after snoop", q, 32'h5A5A_0003);
        ext_write(ad(5, 4, 0), 32'h0BAD_0004);
        acc(0, ad(0, 4, 2), 0, q, dr, dw, wc);
        chk(dr == 0, "R8 unrelated line kept", 32'(dr), 32'd0);
        ext_write(ad(8, 9, 3), 32'h7777_0009);
        acc(0, ad(8, 9, 2), 0, q, dr, dw, wc);
        chk(q == old && dr == 4, "R8 dirty line dropped", q, old);

        // R9: observed write during the fetch of the same line.
        fork
            acc(0, ad(6, 11, 1), 0, q, dr, dw, wc);
            begin
                repeat (4) @(negedge clk);
                ext_write(ad(6, 11, 2), 32'h9999_000B);
            end
        join
        chk(q == model[ad(6, 11, 1)], "R9 data after retry", q, model[ad(6, 11, 1)]);
        chk(dr == 8, "R9 line fetched twice", 32'(dr), 32'd8);
        acc(0, ad(6, 11, 2), 0, q, dr, dw, wc);
        chk(q == 32'h9999_000B && dr == 0, "R9 fresh word cached", q, 32'h9999_000B);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule